// File: doc/BRIEF.md
# Cartridge PRG/CHR bank mapper

This block sits between a console's CPU and PPU buses and the cartridge memories. CPU writes that land in the cartridge register window load a small set of bank registers. The block then turns every CPU address into an 8 KB program ROM bank number and every PPU address into a 1 KB character bank number. The character side also covers the four nametable windows. It decodes only the CPU address lines that select a register, so each register also answers at many other addresses.

The program side has three parts. A 16 KB switchable window starts at $8000, and an 8 KB switchable window starts at $C000. The 8 KB window at $E000 always holds the last bank.

The character side holds eight 8-bit bank registers, B0 to B7. A style register chooses one of five maps that assign these registers to the eight pattern windows and the four nametable windows. The style register also decides two more things. It decides whether 2 KB pattern banks take bit 0 from PPU A10. It decides whether the bit 0 of a nametable bank is replaced by PPU A10, PPU A11 or a constant.

A build parameter swaps CPU address lines A0 and A1, so one netlist suits both board wirings. All ports are plain control pins. There is no stream interface and no back-pressure: outputs follow the addresses combinationally, and register writes take effect one clock after the strobe.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset every register is zero: `prg_bank` is 0 for CPU $8000, `chr_bank` is 0 for PPU $0000, and `prg_ram_en` and `nt_rom_sel` are 0.
- R2: A register is selected only by CPU A15–A12 and by a 2-bit slot taken from A1:A0. Lines A11–A2 have no effect, so $DE6A writes the same register as $D002.
- R3: With `SWAP_A01`=1 the slot is {A0,A1}, so slots 1 and 2 trade places. Slots 0 and 3 keep their place.
- R4: The $8xxx page (any slot) holds a 4-bit value P, taken from data bits 3:0. The $Cxxx page (any slot) holds a 5-bit value Q, taken from data bits 4:0. `prg_bank` is {P, A13} for $8000–$BFFF, Q for $C000–$DFFF, all ones for $E000–$FFFF, and 0 below $8000.
- R5: Page $B with slot 3 is the style register S. `prg_ram_en` is S[7] AND (CPU address in $6000–$7FFF).
- R6: `nt_rom_sel` is S[4] AND PPU A13.
- R7: With S[2:0]=0, pattern window k (PPU A12:A10) uses Bk. The nametable windows $2000/$2400/$2800/$2C00 use B6, B6, B7, B7.
- R8: With S[2:0] = 1 or 5, pattern window k uses B(k/2) as a 2 KB bank. The nametable windows use B4, B5, B6, B7.
- R9: With S[2:0] = 2 or 3, windows 0–3 use B0–B3. Windows 4–5 use B4 and windows 6–7 use B5, as 2 KB banks. The nametables use B6, B7, B6, B7.
- R10: With S[2:0]=4, the pattern windows are as in R7 and the nametables use B6, B7, B6, B7. With S[2:0] = 6 or 7, the pattern windows are as in R9 and the nametables use B6, B6, B7, B7. PPU $3000–$3FFF repeats the nametable windows.
- R11: When S[5]=1, bit 0 of a 2 KB pattern bank is PPU A10. When S[5]=0, the full register value is output.
- R12: When S[5]=1, bit 0 of a nametable bank is replaced according to S[3:0]: 0 or 7 give PPU A10, 3 or 4 give PPU A11, 8 or 15 give 0, and 11 or 12 give 1. Every other value keeps the register bit.
- R13: A register changes only at a clock edge where `cpu_wr`=1 and the address matches. The new value appears on the outputs after that edge. With `cpu_wr`=0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled at the clock edge |
| ppu_addr | input | 14 | PPU address |
| prg_bank | output | PRG_BANK_W | 8 KB program ROM bank for `cpu_addr` |
| prg_ram_en | output | 1 | Program RAM enable |
| chr_bank | output | CHR_W | 1 KB character bank for `ppu_addr`. Bit 0 also serves as the internal nametable page when the nametable source is internal RAM |
| nt_rom_sel | output | 1 | 1: the nametable comes from character ROM; 0: it comes from internal RAM |

## Verification
The assertions assume three things about the inputs. `cpu_wr` is a qualified strobe that is sampled only at the rising clock edge. `cpu_addr` and `cpu_data` hold steady around that edge. Outputs are read only after the address has settled, because the mapping is purely combinational between edges. The bench changes every input half a cycle away from the rising edge and keeps each write to a single cycle. It reads outputs after the inputs have settled and before the next edge. It steps through every style value that selects a distinct map or A10 rule, and on each one it sweeps all sixteen PPU 1 KB windows.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  // Banking style register layout (bit positions are behavioural)
  typedef struct packed {
    logic       ram_en;   // [7]
    logic       spare;    // [6]
    logic       a10_ctl;  // [5]
    logic       nt_rom;   // [4]
    logic [1:0] mirr;     // [3:2]
    logic [1:0] mode;     // [1:0]
  } style_t;

  localparam int unsigned NUM_CHR = 8;
  localparam int unsigned SLOT_W  = 2;

  typedef enum logic [3:0] {
    PG_PRG16 = 4'h8,
    PG_STYLE = 4'hB,
    PG_PRG8  = 4'hC,
    PG_CHR_LO = 4'hD,
    PG_CHR_HI = 4'hE
  } page_e;
endpackage

// File: rtl/map_regs.sv
module map_regs
  import mapper_pkg::*;
#(
  parameter bit SWAP_A01 = 1'b0,
  parameter int PRG16_W  = 4,
  parameter int PRG8_W   = 5,
  parameter int CHR_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [15:0]                     cpu_addr,
  input  logic [7:0]                      cpu_data,
  input  logic                            cpu_wr,
  output logic [PRG16_W-1:0]              prg16_q,
  output logic [PRG8_W-1:0]               prg8_q,
  output style_t                          style_q,
  output logic [NUM_CHR-1:0][CHR_W-1:0]   chr_q
);
  localparam int HALF = NUM_CHR / 2;

  logic [3:0]        page;
  logic [SLOT_W-1:0] slot;
  logic              unused_addr;

  assign page = cpu_addr[15:12];
  generate
    if (SWAP_A01) begin : g_swap
      assign slot = {cpu_addr[0], cpu_addr[1]};
    end else begin : g_straight
      assign slot = cpu_addr[1:0];
    end
  endgenerate
  assign unused_addr = ^cpu_addr[11:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg16_q <= '0;
      prg8_q  <= '0;
      style_q <= '0;
    end else if (cpu_wr) begin
      if (page == PG_PRG16) prg16_q <= cpu_data[PRG16_W-1:0];
      if (page == PG_PRG8)  prg8_q  <= cpu_data[PRG8_W-1:0];
      if (page == PG_STYLE && slot == 2'd3) style_q <= style_t'(cpu_data);
    end
  end

  generate
    for (genvar i = 0; i < NUM_CHR; i++) begin : g_chr
      localparam logic [3:0]        PG = (i < HALF) ? PG_CHR_LO : PG_CHR_HI;
      localparam logic [SLOT_W-1:0] SL = SLOT_W'(i % HALF);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               chr_q[i] <= '0;
        else if (cpu_wr && page == PG && slot == SL) chr_q[i] <= cpu_data[CHR_W-1:0];
      end
    end
  endgenerate

  // R13: nothing moves without a strobe
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> ($stable(chr_q) && $stable(style_q) && $stable(prg16_q) && $stable(prg8_q)));
  // R13 / R5: slot 3 of page B is swap-invariant and loads the style
  p_style_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'hB && cpu_addr[1:0] == 2'b11) |=> (style_q == $past(cpu_data)));
  // R2: low address lines never pick a different register
  p_page8_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'h8) |=> (prg16_q == $past(cpu_data[PRG16_W-1:0])));
endmodule

// File: rtl/prg_map.sv
module prg_map #(
  parameter int PRG16_W    = 4,
  parameter int PRG8_W     = 5,
  parameter int PRG_BANK_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic [PRG16_W-1:0]    prg16_q,
  input  logic [PRG8_W-1:0]     prg8_q,
  input  logic                  ram_en_bit,
  output logic [PRG_BANK_W-1:0] prg_bank,
  output logic                  prg_ram_en
);
  logic unused_low;
  assign unused_low = ^cpu_addr[12:0];

  always_comb begin
    prg_bank = '0;
    unique case (cpu_addr[15:13])
      3'b100, 3'b101: prg_bank[PRG16_W:0] = {prg16_q, cpu_addr[13]};
      3'b110:         prg_bank[PRG8_W-1:0] = prg8_q;
      3'b111:         prg_bank = '1;
      default:        prg_bank = '0;
    endcase
  end

  assign prg_ram_en = ram_en_bit && (cpu_addr[15:13] == 3'b011);

  p_fixed_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (prg_bank == {PRG_BANK_W{1'b1}}));
  p_ram_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prg_ram_en |-> (cpu_addr >= 16'h6000 && cpu_addr < 16'h8000));
endmodule

// File: rtl/chr_map.sv
module chr_map
  import mapper_pkg::*;
#(
  parameter int CHR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [13:0]                   ppu_addr,
  input  style_t                        style_q,
  input  logic [NUM_CHR-1:0][CHR_W-1:0] chr_q,
  output logic [CHR_W-1:0]              chr_bank,
  output logic                          nt_rom_sel
);
  logic [2:0] mode;
  logic [2:0] pw;
  logic [1:0] q;
  logic       is_nt;
  logic [2:0] sel;
  logic       two_kb;
  logic       unused_bits;

  assign mode  = {style_q.mirr[0], style_q.mode};
  assign pw    = ppu_addr[12:10];
  assign q     = ppu_addr[11:10];
  assign is_nt = ppu_addr[13];
  assign unused_bits = ^{ppu_addr[9:0], style_q.spare, style_q.ram_en};

  // window -> register lookup
  always_comb begin
    sel    = pw;
    two_kb = 1'b0;
    if (!is_nt) begin
      unique case (mode)
        3'd0, 3'd4: begin sel = pw; two_kb = 1'b0; end
        3'd1, 3'd5: begin sel = {1'b0, pw[2:1]}; two_kb = 1'b1; end
        default: begin
          if (!pw[2]) begin sel = pw; two_kb = 1'b0; end
          else begin sel = {2'b10, pw[1]}; two_kb = 1'b1; end
        end
      endcase
    end else begin
      unique case (mode)
        3'd1, 3'd5:       sel = {1'b1, q};
        3'd0, 3'd6, 3'd7: sel = {2'b11, q[1]};
        default:          sel = {2'b11, q[0]};
      endcase
    end
  end

  // bit 0 override
  always_comb begin
    chr_bank = chr_q[sel];
    if (style_q.a10_ctl) begin
      if (!is_nt) begin
        if (two_kb) chr_bank[0] = ppu_addr[10];
      end else begin
        unique case ({style_q.mirr, style_q.mode})
          4'd0, 4'd7:   chr_bank[0] = ppu_addr[10];
          4'd3, 4'd4:   chr_bank[0] = ppu_addr[11];
          4'd8, 4'd15:  chr_bank[0] = 1'b0;
          4'd11, 4'd12: chr_bank[0] = 1'b1;
          default:      chr_bank[0] = chr_q[sel][0];
        endcase
      end
    end
  end

  assign nt_rom_sel = style_q.nt_rom && is_nt;

  p_nt_ground_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nt && style_q.a10_ctl && (style_q[3:0] == 4'd8 || style_q[3:0] == 4'd15)) |-> !chr_bank[0]);
  p_nt_vcc_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nt && style_q.a10_ctl && (style_q[3:0] == 4'd11 || style_q[3:0] == 4'd12)) |-> chr_bank[0]);
  p_nt_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nt_rom_sel |-> ppu_addr[13]);
  p_low_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_nt && !pw[2] && (style_q[1:0] != 2'd1)) |-> (chr_bank == chr_q[pw]));
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import mapper_pkg::*;
#(
  parameter bit SWAP_A01   = 1'b0,
  parameter int PRG16_W    = 4,
  parameter int PRG8_W     = 5,
  parameter int PRG_BANK_W = 6,
  parameter int CHR_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_data,
  input  logic                  cpu_wr,
  input  logic [13:0]           ppu_addr,
  output logic [PRG_BANK_W-1:0] prg_bank,
  output logic                  prg_ram_en,
  output logic [CHR_W-1:0]      chr_bank,
  output logic                  nt_rom_sel
);
  logic [PRG16_W-1:0]            prg16_q;
  logic [PRG8_W-1:0]             prg8_q;
  style_t                        style_q;
  logic [NUM_CHR-1:0][CHR_W-1:0] chr_q;

  map_regs #(.SWAP_A01(SWAP_A01), .PRG16_W(PRG16_W), .PRG8_W(PRG8_W), .CHR_W(CHR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
    .prg16_q(prg16_q), .prg8_q(prg8_q), .style_q(style_q), .chr_q(chr_q)
  );

  prg_map #(.PRG16_W(PRG16_W), .PRG8_W(PRG8_W), .PRG_BANK_W(PRG_BANK_W)) u_prg (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .prg16_q(prg16_q), .prg8_q(prg8_q),
    .ram_en_bit(style_q.ram_en), .prg_bank(prg_bank), .prg_ram_en(prg_ram_en)
  );

  chr_map #(.CHR_W(CHR_W)) u_chr (
    .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .style_q(style_q), .chr_q(chr_q),
    .chr_bank(chr_bank), .nt_rom_sel(nt_rom_sel)
  );
endmodule

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [5:0]  prg_bank, prg_bank_s;
  logic        prg_ram_en, prg_ram_en_s, nt_rom_sel, nt_rom_sel_s;
  logic [7:0]  chr_bank, chr_bank_s;

  int checks = 0;
  int errors = 0;
  // model state per instance: [0]=straight, [1]=swapped
  int m_p16 [2];
  int m_p8  [2];
  int m_sty [2];
  int m_chr [2][8];

  always #5 clk = ~clk;

  cart_bank_mapper uut (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_bank(prg_bank), .prg_ram_en(prg_ram_en),
    .chr_bank(chr_bank), .nt_rom_sel(nt_rom_sel));

  cart_bank_mapper #(.SWAP_A01(1'b1)) uut_sw (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_bank(prg_bank_s),
    .prg_ram_en(prg_ram_en_s), .chr_bank(chr_bank_s), .nt_rom_sel(nt_rom_sel_s));

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h (cpu %h ppu %h)", tag, got, exp, cpu_addr, ppu_addr);
    end
  endtask

  function automatic int exp_prg(int i, int a);
    if (a >= 'hE000) return 'h3F;
    if (a >= 'hC000) return m_p8[i];
    if (a >= 'h8000) return m_p16[i] * 2 + ((a >> 13) & 1);
    return 0;
  endfunction

  function automatic int reg_for(int mode, int w);
    int n = w - 8;
    if (w < 8) begin
      if (mode == 0 || mode == 4) return w;
      if (mode == 1 || mode == 5) return w / 2;
      return (w < 4) ? w : 4 + (w - 4) / 2;
    end
    if (mode == 1 || mode == 5) return 4 + n;
    if (mode == 0 || mode >= 6) return 6 + n / 2;
    return 6 + n % 2;
  endfunction

  function automatic bit is_2k(int mode, int w);
    if (w >= 8) return 0;
    if (mode == 1 || mode == 5) return 1;
    if (mode == 2 || mode == 3 || mode >= 6) return w >= 4;
    return 0;
  endfunction

  function automatic int exp_chr(int i, int p);
    int s = m_sty[i];
    int w = (p >> 10) & 15;
    int mode = s & 7;
    int wi = (w >= 12) ? w - 4 : w;
    int v = m_chr[i][reg_for(mode, wi)];
    int a10 = (p >> 10) & 1;
    int a11 = (p >> 11) & 1;
    if ((s & 'h20) != 0) begin
      if (is_2k(mode, wi)) v = (v & 'hFE) | a10;
      else if (wi >= 8) begin
        case (s & 15)
          0, 7:   v = (v & 'hFE) | a10;
          3, 4:   v = (v & 'hFE) | a11;
          8, 15:  v = v & 'hFE;
          11, 12: v = v | 1;
          default: ;
        endcase
      end
    end
    return v;
  endfunction

  function automatic string chr_tag(int i);
    int s = m_sty[i];
    int w = (ppu_addr >> 10) & 15;
    int mode = s & 7;
    if (i == 1) return "R3";
    if (w >= 8 && (s & 'h20) != 0) return "R12";
    if (is_2k(mode, w) && (s & 'h20) != 0) return "R11";
    if (w >= 12) return "R10";
    if (mode == 0) return "R7";
    if (mode == 1 || mode == 5) return "R8";
    if (mode == 2 || mode == 3) return "R9";
    return "R10";
  endfunction

  task automatic compare_all(string ptag);
    check(ptag, prg_bank, exp_prg(0, cpu_addr));
    check("R3", prg_bank_s, exp_prg(1, cpu_addr));
    check("R5", prg_ram_en, ((m_sty[0] >> 7) & 1) && cpu_addr >= 'h6000 && cpu_addr < 'h8000);
    check("R6", nt_rom_sel, ((m_sty[0] >> 4) & 1) && ppu_addr[13]);
    check(chr_tag(0), chr_bank, exp_chr(0, ppu_addr));
    check(chr_tag(1), chr_bank_s, exp_chr(1, ppu_addr));
  endtask

  task automatic model_write(int i, int a, int d);
    int pg = (a >> 12) & 15;
    int sl = (i == 0) ? (a & 3) : (((a & 1) << 1) | ((a >> 1) & 1));
    if (pg == 8) m_p16[i] = d & 15;
    if (pg == 'hC) m_p8[i] = d & 31;
    if (pg == 'hB && sl == 3) m_sty[i] = d;
    if (pg == 'hD) m_chr[i][sl] = d;
    if (pg == 'hE) m_chr[i][4 + sl] = d;
  endtask

  // one cycle: drive at negedge, compare mid-cycle, update model after the edge
  task automatic step(int ca, int cd, bit wr, int pa, string ptag);
    cpu_addr = 16'(ca); cpu_data = 8'(cd); cpu_wr = wr; ppu_addr = 14'(pa);
    #1;
    compare_all(ptag);
    @(posedge clk);
    #1;
    if (wr) for (int i = 0; i < 2; i++) model_write(i, ca, cd);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic wr(int a, int d);
    step(a, d, 1'b1, 0, "R13");
  endtask

  task automatic sweep(string ptag);
    for (int w = 0; w < 16; w++) step(w * 'h1000 + 'h0123, 0, 1'b0, w * 'h400 + 'h155, ptag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int styles [21] = '{'h00, 'h04, 'h01, 'h05, 'h02, 'h03, 'h06, 'h07, 'h20, 'h24, 'h21,
                        'h23, 'h26, 'h28, 'h2C, 'h2B, 'h2F, 'h27, 'h30, 'h90, 'h25};
    for (int i = 0; i < 2; i++) begin
      m_p16[i] = 0; m_p8[i] = 0; m_sty[i] = 0;
      for (int k = 0; k < 8; k++) m_chr[i][k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    step('h8000, 0, 1'b0, 'h0000, "R1");
    check("R1", prg_bank, 0);
    check("R1", chr_bank, 0);
    step('h6000, 0, 1'b0, 'h2000, "R1");
    check("R1", prg_ram_en, 0);
    check("R1", nt_rom_sel, 0);
    // R4: program banks, upper data bits dropped; R2: mirrored addresses
    wr('h8FF2, 'hFA);
    wr('hC123, 'hFF);
    step('h8000, 0, 1'b0, 0, "R4");
    step('hA000, 0, 1'b0, 0, "R4");
    step('hC000, 0, 1'b0, 0, "R4");
    step('hE000, 0, 1'b0, 0, "R4");
    step('h4000, 0, 1'b0, 0, "R4");
    // R13: strobe low changes nothing
    step('h8000, 'h03, 1'b0, 0, "R13");
    step('h8000, 0, 1'b0, 0, "R13");
    check("R13", prg_bank, 'h14);
    // character registers, all odd values; R2 mirror $DE6A
    for (int k = 0; k < 4; k++) wr('hD000 + k, 'h81 + 2 * k);
    for (int k = 0; k < 4; k++) wr('hE000 + k, 'hA1 + 2 * k);
    wr('hDE6A, 'h5B);
    step('hDE6A, 0, 1'b0, 'h0800, "R2");
    check("R2", chr_bank, 'h5B);
    check("R3", chr_bank_s, 'h83);
    // map sweeps over every style class
    foreach (styles[s]) begin
      wr('hB003 | ((s & 1) << 4), styles[s]);
      sweep("R4");
    end
    // R5: RAM enable window edges
    step('h5FFF, 0, 1'b0, 0, "R5");
    step('h6000, 0, 1'b0, 0, "R5");
    step('h7FFF, 0, 1'b0, 0, "R5");
    step('h8000, 0, 1'b0, 0, "R5");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule